// File: doc/BRIEF.md
# Multimode Prescaled Down-Counter Timer

This block is an 8-bit down-counting timer for a peripheral controller. One counter serves three jobs, chosen by a 3-bit mode code: a free-running delay timer, a pulse-width meter that counts only while a gate input is high, and an event counter that steps once for each rising edge of the same gate input. In the delay and pulse-width modes a per-timer prescaler divides the timer clock by 4, 10 or 16. In event mode the prescaler is bypassed. When the count steps down from 1, the counter reloads, a time-out output toggles and a one-cycle interrupt pulse goes to the interrupt controller.

The timer clock `tclk_in` does not have to be related to the bus clock `clk`. It is sampled into the `clk` domain through a two-stage synchroniser, and so is the gate input. Each of these inputs must stay high for at least one `clk` period and low for at least one `clk` period. A single write port reaches two targets. `wr_sel`=0 writes the mode code, and `wr_sel`=1 writes the reload value. The current count is always visible on `rd_data`.

The control logic is a state machine with four states: STOPPED, DELAY, PULSE_WIDTH and EVENT. Reset enters STOPPED. A control write moves from any state to the state its code names, and all other cycles keep the current state. The code map is: 000 goes to STOPPED; 001, 010 and 011 go to DELAY; 100 goes to EVENT; 101, 110 and 111 go to PULSE_WIDTH.

Top module: `mmt_timer`

## Requirements
- R1: While the active-low synchronous reset `rst_n` is low, the state becomes STOPPED, `tout` goes low, `irq` goes low and the prescaler phase clears.
- R2: Reset leaves the count and the reload value unchanged. After reset, `rd_data` still shows the count it held before.
- R3: Bits [2:0] of a control write select the mode. 000 stops counting, so timer clocks have no effect. 001, 010 and 011 select delay mode with divide ratios 4, 10 and 16. 100 selects event mode. 101, 110 and 111 select pulse-width mode with ratios 4, 10 and 16. Bits [7:3] are ignored.
- R4: In delay mode the count drops by one on every Nth synchronised rising edge of `tclk_in`, where N is the divide ratio. When the count steps from 1, it reloads from the reload value, `tout` toggles and `irq` is high for exactly one `clk` cycle.
- R5: A data write while STOPPED loads both the count and the reload value. A data write in any other state changes only the reload value, and the new value takes effect at the next reload.
- R6: In pulse-width mode, prescaled timer clocks count only while the synchronised gate is high. While the gate is low, both the prescaler phase and the count hold.
- R7: In pulse-width mode, a falling edge of the synchronised gate raises `irq` for one cycle.
- R8: In event mode, each synchronised rising edge of `gate_in` decrements the count, with no prescaling. `tclk_in` is ignored in this mode.
- R9: `rd_data` shows the count one `clk` cycle after the count changes.
- R10: A count of 0 stands for 256. Decrementing 0 gives 255, and a reload value of 0 gives a period of 256 steps.
- R11: A control write clears the prescaler phase. No decrement happens in the cycle of a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 = mode code, 1 = reload value |
| wr_data | input | 8 | Write data; the mode code is in bits [2:0] |
| tclk_in | input | 1 | Timer clock, not related to `clk` |
| gate_in | input | 1 | Gate for pulse-width mode, event input for event mode |
| rd_data | output | 8 | Current count, one cycle behind the counter |
| tout | output | 1 | Time-out output; toggles at each reload |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench targets four corner cases:
- The step from 1 that must reload rather than pass through 0. A design that got this wrong would run a 256-step period, or would miss the `tout` toggle.
- A reload value of 0. A design that got this wrong would stop at 0 or reload at once instead of wrapping to 255.
- A data write during a run. A design that got this wrong would disturb the running count at once.
- A control write part-way through a prescale period. A design that got this wrong would keep a stale phase and produce a decrement early.

In pulse-width mode the bench checks that a low gate freezes both the prescaler and the count, and that the gate's falling edge produces an interrupt. It also confirms that timer clocks are ignored when STOPPED and in event mode, and that the count survives reset.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [1:0] {
        TM_STOP  = 2'd0,
        TM_DELAY = 2'd1,
        TM_PULSE = 2'd2,
        TM_EVENT = 2'd3
    } tmode_e;

    localparam int MODE_CODE_W = 3;

endpackage

// File: rtl/mmt_sync_edge.sv
module mmt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~last_q;
    assign fall  = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/mmt_ctrl.sv
module mmt_ctrl
    import mmt_pkg::*;
#(
    parameter int RATIO_A = 4,
    parameter int RATIO_B = 10,
    parameter int RATIO_C = 16,
    parameter int PSC_W   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr,
    input  logic [MODE_CODE_W-1:0] ctl_code,
    input  logic                   gate_lvl,
    output tmode_e                 mode,
    output logic [PSC_W-1:0]       ratio_last,
    output logic                   psc_run,
    output logic                   evt_sel
);
    localparam logic [PSC_W-1:0] LAST_A = PSC_W'(RATIO_A - 1);
    localparam logic [PSC_W-1:0] LAST_B = PSC_W'(RATIO_B - 1);
    localparam logic [PSC_W-1:0] LAST_C = PSC_W'(RATIO_C - 1);

    tmode_e           state_q, state_d;
    logic [PSC_W-1:0] last_q, last_d;

    always_comb begin
        state_d = state_q;
        last_d  = last_q;
        if (ctl_wr) begin
            unique case (ctl_code)
                3'b000:                 state_d = TM_STOP;
                3'b001, 3'b010, 3'b011: state_d = TM_DELAY;
                3'b100:                 state_d = TM_EVENT;
                default:                state_d = TM_PULSE;
            endcase
            unique case (ctl_code[1:0])
                2'd2:    last_d = LAST_B;
                2'd3:    last_d = LAST_C;
                default: last_d = LAST_A;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TM_STOP;
            last_q  <= LAST_A;
        end else begin
            state_q <= state_d;
            last_q  <= last_d;
        end
    end

    always_comb begin
        psc_run = 1'b0;
        evt_sel = 1'b0;
        unique case (state_q)
            TM_STOP:  psc_run = 1'b0;
            TM_DELAY: psc_run = 1'b1;
            TM_PULSE: psc_run = gate_lvl;
            TM_EVENT: evt_sel = 1'b1;
        endcase
    end

    assign mode       = state_q;
    assign ratio_last = last_q;

endmodule

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
    parameter int PSC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             run,
    input  logic [PSC_W-1:0] last,
    output logic             pulse
);
    logic [PSC_W-1:0] psc_q;
    logic             at_last;

    assign at_last = (psc_q == last);
    assign pulse   = tick & run & at_last;

    always_ff @(posedge clk) begin
        if (!rst_n)          psc_q <= '0;
        else if (clr)        psc_q <= '0;
        else if (tick && run) psc_q <= at_last ? '0 : psc_q + PSC_W'(1);
    end

    // R3: the phase never passes the selected ratio
    a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        psc_q <= last);

    // R11: a control write restarts the prescale period
    a_r11_clear_phase: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (psc_q == '0));

endmodule

// File: rtl/mmt_counter.sv
module mmt_counter
    import mmt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [CNT_W-1:0] wdata,
    input  tmode_e           mode,
    input  logic             dec,
    input  logic             gate_fall,
    output logic [CNT_W-1:0] rd_data,
    output logic             tout,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, reload_q, rd_q;
    logic             tout_q, irq_q, term;

    assign term = dec & (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (data_wr) reload_q <= wdata;
            if (data_wr && mode == TM_STOP) cnt_q <= wdata;
            else if (dec)                   cnt_q <= term ? reload_q : cnt_q - ONE;
        end
        rd_q <= cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tout_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            tout_q <= tout_q ^ term;
            irq_q  <= term | ((mode == TM_PULSE) & gate_fall);
        end
    end

    assign rd_data = rd_q;
    assign tout    = tout_q;
    assign irq     = irq_q;

    // R4: every toggle of the time-out output comes with an interrupt
    a_r4_toggle_has_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_q != $past(tout_q)) |-> irq_q);

    // R7: a gate falling edge in pulse-width mode interrupts
    a_r7_gate_fall_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_PULSE && gate_fall) |=> irq_q);

    // R5: a write while stopped lands in the count
    a_r5_stopped_load: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && mode == TM_STOP) |=> (cnt_q == $past(wdata)));

endmodule

// File: rtl/mmt_timer.sv
module mmt_timer
    import mmt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int RATIO_A     = 4,
    parameter int RATIO_B     = 10,
    parameter int RATIO_C     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tclk_in,
    input  logic             gate_in,
    output logic [CNT_W-1:0] rd_data,
    output logic             tout,
    output logic             irq
);
    localparam int PSC_W = $clog2(RATIO_C + 1);

    logic             ctl_wr, data_wr;
    logic             tick, tclk_lvl_unused, tclk_fall_unused;
    logic             gate_lvl, gate_rise, gate_fall;
    tmode_e           mode;
    logic [PSC_W-1:0] ratio_last;
    logic             psc_run, evt_sel, pre_pulse, dec;
    logic             unused_hi_bits;

    assign ctl_wr         = wr_en & ~wr_sel;
    assign data_wr        = wr_en & wr_sel;
    assign unused_hi_bits = ^wr_data[CNT_W-1:MODE_CODE_W] ^ tclk_lvl_unused ^ tclk_fall_unused;

    mmt_sync_edge #(.STAGES(SYNC_STAGES)) u_tclk_sync (
        .clk(clk), .rst_n(rst_n), .async_in(tclk_in),
        .level(tclk_lvl_unused), .rise(tick), .fall(tclk_fall_unused)
    );

    mmt_sync_edge #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .async_in(gate_in),
        .level(gate_lvl), .rise(gate_rise), .fall(gate_fall)
    );

    mmt_ctrl #(
        .RATIO_A(RATIO_A), .RATIO_B(RATIO_B), .RATIO_C(RATIO_C), .PSC_W(PSC_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
        .ctl_code(wr_data[MODE_CODE_W-1:0]), .gate_lvl(gate_lvl),
        .mode(mode), .ratio_last(ratio_last), .psc_run(psc_run), .evt_sel(evt_sel)
    );

    mmt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .clr(ctl_wr), .tick(tick),
        .run(psc_run), .last(ratio_last), .pulse(pre_pulse)
    );

    assign dec = ~ctl_wr & (evt_sel ? gate_rise : pre_pulse);

    mmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wdata(wr_data),
        .mode(mode), .dec(dec), .gate_fall(gate_fall),
        .rd_data(rd_data), .tout(tout), .irq(irq)
    );

    // R1: outputs are quiet when reset is released
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!tout && !irq));

    // R3: the stopped state never leads to an interrupt
    a_r3_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_STOP) |=> !irq);

endmodule

// File: tb/mmt_timer_test.sv
`timescale 1ns/1ps
module mmt_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tclk_in = 1'b0, gate_in = 1'b0;
    logic [7:0] rd_data;
    logic       tout, irq;

    int checks = 0, failures = 0, irq_count = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mmt_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tclk_in(tclk_in), .gate_in(gate_in), .rd_data(rd_data), .tout(tout), .irq(irq)
    );

    // Behavioural reference: mode 0 stop, 1 delay, 2 pulse, 3 event
    int m_t[3], m_g[3];
    int m_mode, m_ratio, m_psc, m_cnt, m_rel, m_rd;
    bit m_known = 0, m_rd_known = 0, m_tout, m_irq;

    always @(posedge clk) begin
        bit tick, ev, fall, en, pre, dec, tc, ctl, dat;
        m_rd       = m_cnt;
        m_rd_known = m_known;
        if (!rst_n) begin
            m_t = '{0, 0, 0}; m_g = '{0, 0, 0};
            m_mode = 0; m_ratio = 4; m_psc = 0; m_tout = 0; m_irq = 0;
        end else begin
            tick = (m_t[1] == 1) && (m_t[2] == 0);
            ev   = (m_g[1] == 1) && (m_g[2] == 0);
            fall = (m_g[1] == 0) && (m_g[2] == 1);
            ctl  = wr_en && !wr_sel;
            dat  = wr_en && wr_sel;
            en   = (m_mode == 1) || (m_mode == 2 && m_g[1] == 1);
            pre  = tick && en && (m_psc == m_ratio - 1);
            dec  = !ctl && ((m_mode == 3) ? ev : pre);
            tc   = dec && m_cnt == 1;
            m_irq = tc || (m_mode == 2 && fall);
            if (tc) m_tout = !m_tout;
            if (dat && m_mode == 0) begin m_cnt = wr_data; m_known = 1; end
            else if (dec) m_cnt = tc ? m_rel : (m_cnt + 255) % 256;
            if (dat) m_rel = wr_data;
            if (ctl) m_psc = 0;
            else if (tick && en) m_psc = pre ? 0 : m_psc + 1;
            if (ctl) begin
                case (wr_data[2:0])
                    3'b000: m_mode = 0;
                    3'b100: m_mode = 3;
                    default: m_mode = wr_data[2] ? 2 : 1;
                endcase
                m_ratio = (wr_data[1:0] == 2) ? 10 : (wr_data[1:0] == 3) ? 16 : 4;
            end
            m_t[2] = m_t[1]; m_t[1] = m_t[0]; m_t[0] = tclk_in;
            m_g[2] = m_g[1]; m_g[1] = m_g[0]; m_g[0] = gate_in;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (irq === 1'b1) irq_count++;
        if (!done) begin
            check("R4 model tout", int'(tout), int'(m_tout));
            check("R7 model irq", int'(irq), int'(m_irq));
            if (m_rd_known) check("R9 model rd_data", int'(rd_data), m_rd);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit sel, int d);
        @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = 8'(d);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic tpulse(int n);
        for (int i = 0; i < n; i++) begin
            tclk_in = 1; cyc(2); tclk_in = 0; cyc(2);
        end
        cyc(6);
    endtask

    task automatic gpulse();
        gate_in = 1; cyc(2); gate_in = 0; cyc(8);
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        cyc(4); rst_n = 1; cyc(2);
        check("R1 tout after reset", int'(tout), 0);
        check("R1 irq after reset", int'(irq), 0);

        wr(1, 3); cyc(3);
        check("R5 stopped write loads count", int'(rd_data), 3);
        tpulse(8);
        check("R3 stopped ignores tclk", int'(rd_data), 3);

        wr(0, 8'hF9);   // code 001 with ignored upper bits set
        tpulse(4);
        check("R4 divide by 4 step", int'(rd_data), 2);
        tpulse(8);
        check("R4 reload after 1", int'(rd_data), 3);
        check("R4 tout toggled", int'(tout), 1);
        check("R4 one irq", irq_count, 1);

        wr(1, 5); cyc(3);
        check("R5 running write leaves count", int'(rd_data), 3);
        tpulse(12);
        check("R5 new reload used", int'(rd_data), 5);
        check("R4 tout toggled back", int'(tout), 0);

        rst_n = 0; cyc(3); rst_n = 1; cyc(2);
        check("R2 count kept over reset", int'(rd_data), 5);
        check("R1 tout low after reset", int'(tout), 0);

        wr(1, 2); wr(0, 3'b010);
        tpulse(9);
        check("R3 divide by 10 not yet", int'(rd_data), 2);
        tpulse(1);
        check("R3 divide by 10 step", int'(rd_data), 1);

        wr(0, 3'b001); tpulse(3); wr(0, 3'b001); tpulse(3);
        check("R11 control write restarts phase", int'(rd_data), 1);
        tpulse(1);
        check("R11 step after full period", int'(rd_data), 2);

        wr(0, 0); wr(1, 4); wr(0, 3'b101);
        tpulse(8);
        check("R6 gate low holds", int'(rd_data), 4);
        gate_in = 1; cyc(6);
        tpulse(4);
        check("R6 gate high counts", int'(rd_data), 3);
        base = irq_count;
        gate_in = 0; cyc(6);
        check("R7 irq on gate fall", irq_count, base + 1);

        wr(0, 0); wr(1, 2); wr(0, 3'b100);
        tpulse(8);
        check("R8 event ignores tclk", int'(rd_data), 2);
        gpulse();
        check("R8 edge decrements", int'(rd_data), 1);
        base = irq_count;
        gpulse();
        check("R8 edge reloads", int'(rd_data), 2);
        check("R8 irq at reload", irq_count, base + 1);

        wr(0, 0); wr(1, 0); wr(0, 3'b100);
        gpulse();
        check("R10 zero wraps to 255", int'(rd_data), 255);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule